// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block is a bus master that fetches one 16-bit word from a three-wire serial EEPROM with a separate chip select. A host places a register address on `addr_i` and pulses `start_i`. The block raises chip select and shifts out a read command. It then clocks in the sixteen data bits and drops chip select. After a hold gap it returns the word on `rdata_o` together with a one-cycle `done_o` strobe.

Every timing phase is a parameter counted in system-clock cycles. These phases are chip-select setup, data-in setup before the clock rises, clock high, clock low and chip-select hold. The same bus timing is therefore met at any system clock frequency. The defaults suit a 125 MHz clock and give 1 µs setup and hold, 0.4 µs data setup, and a clock period above 4 µs. The EEPROM data-out line passes through a two-stage synchronizer before it is sampled, so `SKH_CYC` must exceed the synchronizer depth. Only the read command is issued.

Top module: `mw_eeprom_reader`

## Requirements
- R1: The command is 10 bits long and is sent most significant bit first, one bit per serial-clock rising edge. Its value is 0x180 OR the 4-bit address: a zero, the start bit 1, the read opcode 1 then 0, two zero pad bits, and then address bits 3 down to 0.
- R2: Chip select rises exactly CSS_CYC + DIS_CYC cycles before the first serial-clock rise. The serial clock is never high while chip select is low.
- R3: Data-in takes its new value DIS_CYC cycles before each serial-clock rise. It does not change while the serial clock is high.
- R4: Each serial-clock high phase lasts exactly SKH_CYC cycles. Between consecutive pulses of one frame, the clock stays low for exactly SKL_CYC + DIS_CYC cycles.
- R5: During the 16 data-bit clocks (rises 11 to 26), data-in is held at 0.
- R6: Exactly 26 serial-clock pulses occur per transfer. The data-out value sampled at the end of each of the last 16 high phases is assembled MSB first into `rdata_o`, which holds the word from `done_o` until the next transfer samples data.
- R7: Chip select falls SKL_CYC cycles after the last clock pulse ends. It stays low for CSH_CYC cycles before `done_o` rises. `done_o` is high for exactly one cycle.
- R8: A `start_i` pulse while `busy_o` is high is ignored. It starts no later frame and does not change the word returned.
- R9: During and after reset, chip select, the serial clock, data-in, `busy_o` and `done_o` are all 0.
- R10: `busy_o` rises the cycle after an accepted start and stays high until it falls in the same cycle that `done_o` rises. A start in the cycle `done_o` is seen is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | One-cycle request to read a word |
| addr_i | input | 4 | EEPROM word address, sampled with an accepted start |
| busy_o | output | 1 | High while a transfer is in progress |
| done_o | output | 1 | One-cycle strobe when `rdata_o` is valid |
| rdata_o | output | 16 | Word read from the EEPROM |
| ee_cs_o | output | 1 | EEPROM chip select, active high |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_di_o | output | 1 | Serial data toward the EEPROM |
| ee_do_i | input | 1 | Serial data from the EEPROM (asynchronous) |

## Verification
The results fall at fixed distances from a start. `busy_o` is due one cycle after the start is registered. The first clock rise comes CSS+DIS cycles after chip select, and each pulse lasts SKH cycles with SKL+DIS low cycles between pulses. `done_o` comes CSH cycles after chip select falls. The bench samples every output on the falling clock edge, halfway between register updates. It counts run lengths in whole cycles and compares each run with the exact figure above, not a bound. Returned words and captured command frames are matched against a queue of expected items when `done_o` is seen. Starts issued back to back and starts issued during a transfer check that acceptance happens exactly at the cycle boundaries given by R8 and R10.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CSS   = 3'd1,
    ST_SETUP = 3'd2,
    ST_HIGH  = 3'd3,
    ST_LOW   = 3'd4,
    ST_CSH   = 3'd5
  } mw_state_t;

  // Leading zero, start bit, read opcode (1,0)
  localparam logic [3:0] MW_READ_LEAD = 4'b0110;

  function automatic int mw_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  generate
    if (STAGES <= 1) begin : g_single
      logic q_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= 1'b0;
        else        q_r <= d_i;
      end
      assign q_o = q_r;
    end else begin : g_chain
      logic [STAGES-1:0] q_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= {q_r[STAGES-2:0], d_i};
      end
      assign q_o = q_r[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/mw_phase_timer.sv
module mw_phase_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         expired_o
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign expired_o = (cnt_q == '0);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_en = 1'b1;
      cnt_d  = load_val_i;
    end else if (!expired_o) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/mw_frame_shifter.sv
module mw_frame_shifter #(
  parameter int ADDR_W = 4,
  parameter int PAD_W  = 2,
  parameter int DATA_W = 16,
  localparam int CMD_W = 4 + PAD_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cmd_shift_i,
  output logic              cmd_msb_o,
  output logic              cmd_next_o,
  input  logic              rx_cap_i,
  input  logic              rx_bit_i,
  output logic [DATA_W-1:0] rx_word_o
);

  logic [CMD_W-1:0]  cmd_q, cmd_d;
  logic              cmd_en;
  logic [DATA_W-1:0] rx_q, rx_d;

  always_comb begin
    cmd_en = cmd_load_i | cmd_shift_i;
    if (cmd_load_i) cmd_d = {mw_pkg::MW_READ_LEAD, {PAD_W{1'b0}}, addr_i};
    else            cmd_d = {cmd_q[CMD_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (cmd_en) cmd_q <= cmd_d;
  end

  assign cmd_msb_o  = cmd_q[CMD_W-1];
  assign cmd_next_o = cmd_q[CMD_W-2];

  assign rx_d = {rx_q[DATA_W-2:0], rx_bit_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rx_q <= '0;
    else if (rx_cap_i) rx_q <= rx_d;
  end

  assign rx_word_o = rx_q;

endmodule

// File: rtl/mw_eeprom_reader.sv
module mw_eeprom_reader #(
  parameter int ADDR_W      = 4,
  parameter int PAD_W       = 2,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int CSS_CYC     = 125,
  parameter int DIS_CYC     = 50,
  parameter int SKH_CYC     = 250,
  parameter int SKL_CYC     = 250,
  parameter int CSH_CYC     = 125
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ee_cs_o,
  output logic              ee_sk_o,
  output logic              ee_di_o,
  input  logic              ee_do_i
);
  import mw_pkg::*;

  localparam int CMD_W   = 4 + PAD_W + ADDR_W;
  localparam int TOT_W   = CMD_W + DATA_W;
  localparam int BIT_W   = $clog2(TOT_W + 1);
  localparam int MAX_CYC = mw_max(mw_max(mw_max(CSS_CYC, DIS_CYC), mw_max(SKH_CYC, SKL_CYC)), CSH_CYC);
  localparam int TMR_W   = $clog2(MAX_CYC + 1);
  localparam logic [BIT_W-1:0] CMD_BITS = BIT_W'(CMD_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(TOT_W - 1);
  localparam logic [TMR_W-1:0] T_CSS = TMR_W'(CSS_CYC - 1);
  localparam logic [TMR_W-1:0] T_DIS = TMR_W'(DIS_CYC - 1);
  localparam logic [TMR_W-1:0] T_SKH = TMR_W'(SKH_CYC - 1);
  localparam logic [TMR_W-1:0] T_SKL = TMR_W'(SKL_CYC - 1);
  localparam logic [TMR_W-1:0] T_CSH = TMR_W'(CSH_CYC - 1);

  mw_state_t        state_q, state_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             cs_q, cs_d, sk_q, sk_d, di_q, di_d, done_q, done_d;
  logic             tmr_load, tmr_exp;
  logic [TMR_W-1:0] tmr_val;
  logic             cmd_load, cmd_shift, cmd_msb, cmd_next;
  logic             rx_cap, do_sync;
  logic             in_data;

  mw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(ee_do_i), .q_o(do_sync)
  );

  mw_phase_timer #(.W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .load_val_i(tmr_val),
    .expired_o(tmr_exp)
  );

  mw_frame_shifter #(.ADDR_W(ADDR_W), .PAD_W(PAD_W), .DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .cmd_load_i(cmd_load), .addr_i(addr_i), .cmd_shift_i(cmd_shift),
    .cmd_msb_o(cmd_msb), .cmd_next_o(cmd_next),
    .rx_cap_i(rx_cap), .rx_bit_i(do_sync), .rx_word_o(rdata_o)
  );

  assign in_data = (bit_q >= CMD_BITS);

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    bit_d     = bit_q;
    cs_d      = cs_q;
    sk_d      = sk_q;
    di_d      = di_q;
    done_d    = 1'b0;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    cmd_load  = 1'b0;
    cmd_shift = 1'b0;
    rx_cap    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d  = ST_CSS;
          cs_d     = 1'b1;
          bit_d    = '0;
          cmd_load = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = T_CSS;
        end
      end
      ST_CSS: begin
        if (tmr_exp) begin
          state_d  = ST_SETUP;
          di_d     = cmd_msb;
          tmr_load = 1'b1;
          tmr_val  = T_DIS;
        end
      end
      ST_SETUP: begin
        if (tmr_exp) begin
          state_d  = ST_HIGH;
          sk_d     = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = T_SKH;
        end
      end
      ST_HIGH: begin
        if (tmr_exp) begin
          state_d  = ST_LOW;
          sk_d     = 1'b0;
          rx_cap   = in_data;
          tmr_load = 1'b1;
          tmr_val  = T_SKL;
        end
      end
      ST_LOW: begin
        if (tmr_exp) begin
          bit_d     = bit_q + 1'b1;
          cmd_shift = ~in_data;
          tmr_load  = 1'b1;
          if (bit_q == LAST_BIT) begin
            state_d = ST_CSH;
            cs_d    = 1'b0;
            di_d    = 1'b0;
            tmr_val = T_CSH;
          end else begin
            state_d = ST_SETUP;
            di_d    = ((bit_q + 1'b1) < CMD_BITS) ? cmd_next : 1'b0;
            tmr_val = T_DIS;
          end
        end
      end
      ST_CSH: begin
        if (tmr_exp) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      cs_q    <= 1'b0;
      sk_q    <= 1'b0;
      di_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      cs_q    <= cs_d;
      sk_q    <= sk_d;
      di_q    <= di_d;
      done_q  <= done_d;
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
  assign ee_cs_o = cs_q;
  assign ee_sk_o = sk_q;
  assign ee_di_o = di_q;

  // Assertions
  a_r2_sk_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk_o |-> ee_cs_o);
  a_r3_di_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HIGH) |-> $stable(ee_di_o));
  a_r5_di_low_data: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && (state_q == ST_SETUP || state_q == ST_HIGH)) |-> !ee_di_o);
  a_r7_done_cs_low: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!ee_cs_o && !ee_sk_o));
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r10_cs_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ee_cs_o |-> busy_o);
  a_r10_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  a_r8_busy_holds_state: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && state_q == ST_CSS && !tmr_exp) |=> (state_q == ST_CSS));

endmodule

// File: tb/sim_mw_eeprom_reader.sv
module sim_mw_eeprom_reader;

  localparam int CSS = 5;
  localparam int DIS = 2;
  localparam int SKH = 4;
  localparam int SKL = 3;
  localparam int CSH = 6;

  typedef struct packed {
    logic [3:0]  addr;
    logic [15:0] data;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [3:0]  addr;
  logic        busy, done, cs, sk, di;
  logic [15:0] rdata;
  logic        do_r = 1'b0;

  int checks = 0;
  int errors = 0;
  exp_t q[$];

  mw_eeprom_reader #(
    .CSS_CYC(CSS), .DIS_CYC(DIS), .SKH_CYC(SKH), .SKL_CYC(SKL), .CSH_CYC(CSH)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr),
    .busy_o(busy), .done_o(done), .rdata_o(rdata),
    .ee_cs_o(cs), .ee_sk_o(sk), .ee_di_o(di), .ee_do_i(do_r)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [15:0] rom_word(input logic [3:0] a);
    return {a, ~a, a ^ 4'h9, 4'hC ^ {a[0], a[3:1]}};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // EEPROM model: captures command on clock rise, drives data after rise
  int          rc = 0;
  logic [9:0]  cmd_cap = '0;
  always @(posedge sk or negedge cs) begin
    if (!cs) begin
      rc = 0;
      do_r = 1'b0;
    end else begin
      rc = rc + 1;
      if (rc <= 10) cmd_cap = {cmd_cap[8:0], di};
      if (rc == 10) do_r = 1'b0;
      else if (rc > 10 && rc <= 26) do_r = rom_word(cmd_cap[3:0])[26 - rc];
    end
  end

  // Monitor: timing checks and scoreboard
  logic prev_sk = 1'b0, prev_cs = 1'b0, prev_di = 1'b0;
  int   cs_cnt = 0, hi_cnt = 0, lo_cnt = 0, csl_cnt = 0, rises = 0;
  bit   di_moved = 0, in_xfer = 0, busy_gap = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cs && !prev_cs) rises = 0;
      if (sk && !prev_sk) begin
        if (rises == 0) chk(cs_cnt == CSS + DIS, "R2 cs-to-first-clock", cs_cnt, CSS + DIS);
        else chk(lo_cnt == SKL + DIS, "R4 low length", lo_cnt, SKL + DIS);
        if (rises >= 10) chk(di == 1'b0, "R5 data-in low", di, 0);
        rises++;
        lo_cnt = 0;
        di_moved = 0;
      end
      if (!sk && prev_sk) begin
        chk(hi_cnt == SKH, "R4 high length", hi_cnt, SKH);
        chk(!di_moved, "R3 data-in stable while high", di_moved, 0);
        hi_cnt = 0;
      end
      if (sk && prev_sk && di != prev_di) di_moved = 1;
      if (sk) hi_cnt++;
      if (cs && !sk && rises > 0) lo_cnt++;
      if (cs && rises == 0 && !sk) cs_cnt++;
      if (!cs) cs_cnt = 0;
      if (!cs) csl_cnt++; else csl_cnt = 0;
      if (sk && !cs) chk(0, "R2 clock while deselected", 1, 0);
      if (busy) in_xfer = 1;
      if (in_xfer && !busy && !done) busy_gap = 1;
      if (done) begin
        exp_t e;
        chk(q.size() > 0, "R6 unexpected done", q.size(), 1);
        if (q.size() > 0) begin
          e = q.pop_front();
          chk(rdata == e.data, "R6 word", rdata, e.data);
          chk(cmd_cap == (10'h180 | {6'd0, e.addr}), "R1 command frame", cmd_cap, 10'h180 | {6'd0, e.addr});
        end
        chk(rises == 26, "R6 clock pulse count", rises, 26);
        chk(csl_cnt == CSH + 1, "R7 cs hold before done", csl_cnt - 1, CSH);
        chk(!busy && !busy_gap, "R10 busy span", busy_gap, 0);
        in_xfer = 0;
        busy_gap = 0;
      end
      if (done && $past(done)) chk(0, "R7 done pulse width", 2, 1);
    end
    prev_sk = sk;
    prev_cs = cs;
    prev_di = di;
  end

  task automatic issue(input logic [3:0] a);
    exp_t e;
    e.addr = a;
    e.data = rom_word(a);
    q.push_back(e);
    start = 1'b1;
    addr  = a;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10 busy after start", busy, 1);
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  // Watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    addr  = '0;
    repeat (3) @(negedge clk);
    chk({cs, sk, di, busy, done} == 5'b0, "R9 reset outputs", {cs, sk, di, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({cs, sk, di, busy, done} == 5'b0, "R9 idle after reset", {cs, sk, di, busy, done}, 0);

    issue(4'h0);
    wait_done();
    // R10: start in the done cycle is accepted
    issue(4'hF);
    wait_done();
    issue(4'h5);
    wait_done();
    issue(4'hA);
    repeat (20) @(negedge clk);
    // R8: start while busy must be ignored
    start = 1'b1;
    addr  = 4'h3;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    begin
      bit stray = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (busy || cs) stray = 1;
      end
      chk(!stray, "R8 ignored start began no frame", stray, 0);
      chk(rdata == rom_word(4'hA), "R8 word unchanged", rdata, rom_word(4'hA));
      chk(q.size() == 0, "R8 scoreboard drained", q.size(), 0);
    end
    issue(4'h6);
    wait_done();
    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule